// File: doc/BRIEF.md
# Nibble-Addressed Control Register Host Interface

This block is the parallel host port of a display driver. The host uses an 8-bit data bus with an active-low chip select, a register/RAM select line and active-low read and write strobes. When the select line is high, a write is self-addressed. The upper nibble of the byte names the register and the lower nibble carries the value. Reads are indirect. The host first writes the target address into a read pointer register, and a later read cycle returns that register.

The control registers sit in banks chosen by a 3-bit bank field. Bank 0 holds an 8-bit X address and a 7-bit Y address for the display RAM, each written as two nibbles. Only Y values from 0 to 67 are accepted. When the select line is low, each access becomes a one-cycle strobe on a RAM port. The strobe carries the current {Y, X} address and the full data byte.

The host lines are resynchronised to the block clock. A small state machine follows each strobe through these states: `ST_IDLE`, `ST_WR_LOW` (write strobe held low), `ST_COMMIT` (one cycle that applies the write), `ST_RD_FIRST` (first cycle of a read) and `ST_RD_HOLD` (read still held). The transitions are as follows:
- `ST_IDLE` goes to `ST_WR_LOW` when select and write are both low. Write takes priority over read.
- `ST_IDLE` goes to `ST_RD_FIRST` when select and read are both low.
- `ST_WR_LOW` goes to `ST_COMMIT` once the write strobe has risen.
- `ST_COMMIT` always returns to `ST_IDLE`.
- `ST_RD_FIRST` goes to `ST_RD_HOLD` while read and select stay low.
- Either read state returns to `ST_IDLE` as soon as read or select goes high.

Top module: `nib_reg_if`

## Requirements
- R1: After reset the X address, Y address, read pointer and bank are 0. `y_err` is 0, `bus_oe` is 0 and both RAM strobes are low.
- R2: With `cs_n` low and `rs` high, a write stores `bus_in[3:0]` into the register addressed by `bus_in[7:4]`. The store takes effect when `wr_n` rises. Registers read back through the read pointer reflect the new value.
- R3: A register read has two steps. The first is a write of the target address to the read pointer at address 0xF. A read cycle with `rs` high then drives {4'hF, register nibble} on `bus_out`.
- R4: `bus_oe` rises on the third clock edge after `cs_n` and `rd_n` are presented low. It falls on the third edge after either is released. It is low at all other times.
- R5: In bank 0, address 0 holds X bits 3:0 and address 1 holds X bits 7:4.
- R6: In bank 0, address 2 holds Y bits 3:0 and address 3 holds Y bits 6:4. The upper write uses data bits 2:0, and data bit 3 is ignored. Reading address 3 returns {0, Y[6:4]}.
- R7: A Y nibble write that would make Y greater than 67 (0x43) leaves Y unchanged and sets `y_err`. `y_err` stays set until reset.
- R8: Address 0xE is the bank register and data bits 2:0 select the bank, with bit 3 ignored. Addresses 0xE and 0xF work in every bank. In a nonzero bank, addresses 0 to 3 are undefined.
- R9: Writes to undefined addresses have no effect, and reading an undefined address returns nibble 0xF.
- R10: A write with `rs` low gives exactly one cycle of `ram_we`. During that cycle `ram_addr` = {Y, X} and `ram_wdata` is the full byte. No register changes.
- R11: A read with `rs` low gives exactly one cycle of `ram_re` in the first cycle of `bus_oe`. While `bus_oe` is high, `bus_out` carries `ram_rdata`.
- R12: Reading the bank register returns {4'hF, 0, bank}. Reading the pointer register returns {4'hF, pointer}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | 1 = control register, 0 = display RAM |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; action on rising edge |
| bus_in | input | 8 | Data bus from host |
| bus_out | output | 8 | Data bus to host, valid while bus_oe |
| bus_oe | output | 1 | Bus drive enable (pad tristate control) |
| ram_we | output | 1 | One-cycle RAM write strobe |
| ram_re | output | 1 | One-cycle RAM read strobe |
| ram_addr | output | 15 | Current {Y, X} RAM address |
| ram_wdata | output | 8 | Byte for RAM write |
| ram_rdata | input | 8 | Byte returned by RAM |
| y_err | output | 1 | Sticky out-of-range Y write flag |

## Verification
Several properties are checked on every cycle:
- Bus drive only follows a select-and-read seen three edges earlier.
- The two RAM strobes never overlap, and each lasts a single cycle.
- The RAM read strobe only appears while the bus is driven.
- Y never exceeds 67, and the error flag never clears.
- A register read always drives the upper nibble high.

The stored values can only be shown by the bench's scenarios. These cover each nibble mapping, the ignored bit 3 on Y, the discarded out-of-range Y write, bank switching that hides X and Y, undefined addresses, and the address and data carried on a RAM strobe.

// File: rtl/nri_pkg.sv
package nri_pkg;
    localparam int NIB_W  = 4;
    localparam int DATA_W = 2 * NIB_W;
    localparam int X_W    = 2 * NIB_W;
    localparam int Y_W    = 7;
    localparam int BANK_W = 3;
    localparam int Y_MAX_DEF = 67;

    localparam logic [NIB_W-1:0] A_XLO  = 4'h0;
    localparam logic [NIB_W-1:0] A_XHI  = 4'h1;
    localparam logic [NIB_W-1:0] A_YLO  = 4'h2;
    localparam logic [NIB_W-1:0] A_YHI  = 4'h3;
    localparam logic [NIB_W-1:0] A_BANK = 4'hE;
    localparam logic [NIB_W-1:0] A_RPTR = 4'hF;
    localparam logic [NIB_W-1:0] NIB_UNDEF = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LOW,
        ST_COMMIT,
        ST_RD_FIRST,
        ST_RD_HOLD
    } nri_state_e;
endpackage

// File: rtl/nri_sync.sv
module nri_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/nri_ctrl.sv
module nri_ctrl
    import nri_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_cs_n,
    input  logic              s_rs,
    input  logic              s_rd_n,
    input  logic              s_wr_n,
    input  logic [DATA_W-1:0] s_data,
    output nri_state_e        state,
    output logic              lat_rs,
    output logic [DATA_W-1:0] lat_data,
    output logic              reg_wr,
    output logic              ram_wr,
    output logic              ram_rd,
    output logic              bus_drive
);
    nri_state_e state_n;
    logic       capture;

    always_comb begin
        state_n = state;
        capture = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!s_cs_n && !s_wr_n) begin
                    state_n = ST_WR_LOW;
                    capture = 1'b1;
                end else if (!s_cs_n && !s_rd_n) begin
                    state_n = ST_RD_FIRST;
                    capture = 1'b1;
                end
            end
            ST_WR_LOW: begin
                if (s_wr_n) state_n = ST_COMMIT;
                else        capture = 1'b1;
            end
            ST_COMMIT: state_n = ST_IDLE;
            ST_RD_FIRST, ST_RD_HOLD: begin
                if (s_rd_n || s_cs_n) state_n = ST_IDLE;
                else                  state_n = ST_RD_HOLD;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lat_rs   <= 1'b0;
            lat_data <= '0;
        end else begin
            state <= state_n;
            if (capture) begin
                lat_rs   <= s_rs;
                lat_data <= s_data;
            end
        end
    end

    always_comb begin
        reg_wr    = 1'b0;
        ram_wr    = 1'b0;
        ram_rd    = 1'b0;
        bus_drive = 1'b0;
        unique case (state)
            ST_IDLE, ST_WR_LOW: ;
            ST_COMMIT: begin
                reg_wr = lat_rs;
                ram_wr = !lat_rs;
            end
            ST_RD_FIRST: begin
                bus_drive = 1'b1;
                ram_rd    = !lat_rs;
            end
            ST_RD_HOLD: bus_drive = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/nri_regs.sv
module nri_regs
    import nri_pkg::*;
#(
    parameter int Y_MAX = Y_MAX_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NIB_W-1:0] waddr,
    input  logic [NIB_W-1:0] wdata,
    output logic [X_W-1:0]   x_addr,
    output logic [Y_W-1:0]   y_addr,
    output logic [NIB_W-1:0] rd_nib,
    output logic             y_err
);
    localparam int Y_HI_W = Y_W - NIB_W;

    logic [NIB_W-1:0]  ptr_q;
    logic [BANK_W-1:0] bank_q;
    logic [Y_W-1:0]    y_lo_cand;
    logic [Y_W-1:0]    y_hi_cand;
    logic              bank0;

    assign bank0     = (bank_q == '0);
    assign y_lo_cand = {y_addr[Y_W-1:NIB_W], wdata};
    assign y_hi_cand = {wdata[Y_HI_W-1:0], y_addr[NIB_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            bank_q <= '0;
            x_addr <= '0;
            y_addr <= '0;
            y_err  <= 1'b0;
        end else if (wr_en) begin
            if (waddr == A_RPTR) begin
                ptr_q <= wdata;
            end else if (waddr == A_BANK) begin
                bank_q <= wdata[BANK_W-1:0];
            end else if (bank0) begin
                case (waddr)
                    A_XLO: x_addr[NIB_W-1:0] <= wdata;
                    A_XHI: x_addr[X_W-1:NIB_W] <= wdata;
                    A_YLO: begin
                        if (int'(y_lo_cand) <= Y_MAX) y_addr <= y_lo_cand;
                        else                          y_err  <= 1'b1;
                    end
                    A_YHI: begin
                        if (int'(y_hi_cand) <= Y_MAX) y_addr <= y_hi_cand;
                        else                          y_err  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_nib = NIB_UNDEF;
        if (ptr_q == A_RPTR) begin
            rd_nib = ptr_q;
        end else if (ptr_q == A_BANK) begin
            rd_nib = '0;
            rd_nib[BANK_W-1:0] = bank_q;
        end else if (bank0) begin
            case (ptr_q)
                A_XLO: rd_nib = x_addr[NIB_W-1:0];
                A_XHI: rd_nib = x_addr[X_W-1:NIB_W];
                A_YLO: rd_nib = y_addr[NIB_W-1:0];
                A_YHI: begin
                    rd_nib = '0;
                    rd_nib[Y_HI_W-1:0] = y_addr[Y_W-1:NIB_W];
                end
                default: rd_nib = NIB_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/nib_reg_if.sv
module nib_reg_if
    import nri_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int Y_MAX       = Y_MAX_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                rs,
    input  logic                rd_n,
    input  logic                wr_n,
    input  logic [DATA_W-1:0]   bus_in,
    output logic [DATA_W-1:0]   bus_out,
    output logic                bus_oe,
    output logic                ram_we,
    output logic                ram_re,
    output logic [Y_W+X_W-1:0]  ram_addr,
    output logic [DATA_W-1:0]   ram_wdata,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic                y_err
);
    localparam int IN_W = DATA_W + 4;
    localparam logic [IN_W-1:0] IN_IDLE = {1'b1, 1'b0, 1'b1, 1'b1, {DATA_W{1'b0}}};

    logic [IN_W-1:0]   s_vec;
    logic              s_cs_n, s_rs, s_rd_n, s_wr_n;
    logic [DATA_W-1:0] s_data;
    nri_state_e        state;
    logic              lat_rs;
    logic [DATA_W-1:0] lat_data;
    logic              reg_wr;
    logic              bus_drive;
    logic [X_W-1:0]    x_addr;
    logic [Y_W-1:0]    y_addr;
    logic [NIB_W-1:0]  rd_nib;

    nri_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, rs, rd_n, wr_n, bus_in}),
        .q     (s_vec)
    );

    assign {s_cs_n, s_rs, s_rd_n, s_wr_n, s_data} = s_vec;

    nri_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_cs_n    (s_cs_n),
        .s_rs      (s_rs),
        .s_rd_n    (s_rd_n),
        .s_wr_n    (s_wr_n),
        .s_data    (s_data),
        .state     (state),
        .lat_rs    (lat_rs),
        .lat_data  (lat_data),
        .reg_wr    (reg_wr),
        .ram_wr    (ram_we),
        .ram_rd    (ram_re),
        .bus_drive (bus_drive)
    );

    nri_regs #(.Y_MAX(Y_MAX)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .waddr  (lat_data[DATA_W-1:NIB_W]),
        .wdata  (lat_data[NIB_W-1:0]),
        .x_addr (x_addr),
        .y_addr (y_addr),
        .rd_nib (rd_nib),
        .y_err  (y_err)
    );

    assign bus_oe    = bus_drive;
    assign bus_out   = !bus_drive ? '0 : (lat_rs ? {{NIB_W{1'b1}}, rd_nib} : ram_rdata);
    assign ram_addr  = {y_addr, x_addr};
    assign ram_wdata = lat_data;
endmodule

// File: rtl/nib_reg_if_chk.sv
module nib_reg_if_chk
    import nri_pkg::*;
#(
    parameter int Y_MAX = Y_MAX_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              bus_oe,
    input logic [DATA_W-1:0] bus_out,
    input logic              ram_we,
    input logic              ram_re,
    input logic              y_err,
    input logic [Y_W-1:0]    y_addr,
    input logic              lat_rs
);
    // R4
    oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> ($past(rd_n, 3) == 1'b0 && $past(cs_n, 3) == 1'b0));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    // R10
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    // R11
    re_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> !ram_re);

    // R11
    re_in_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |-> bus_oe);

    // R7
    y_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(y_addr) <= Y_MAX);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_err |=> y_err);

    // R3
    reg_hi_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && lat_rs) |-> (bus_out[DATA_W-1:NIB_W] == {NIB_W{1'b1}}));
endmodule

bind nib_reg_if nib_reg_if_chk #(.Y_MAX(Y_MAX)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .bus_oe  (bus_oe),
    .bus_out (bus_out),
    .ram_we  (ram_we),
    .ram_re  (ram_re),
    .y_err   (y_err),
    .y_addr  (y_addr),
    .lat_rs  (lat_rs)
);

// File: tb/nib_reg_if_bench.sv
`timescale 1ns/1ps
module nib_reg_if_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rs = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  bus_in = 8'h00;
    logic [7:0]  ram_rdata = 8'h00;
    logic [7:0]  bus_out;
    logic        bus_oe, ram_we, ram_re, y_err;
    logic [14:0] ram_addr;
    logic [7:0]  ram_wdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nib_reg_if u_nib_reg_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .rd_n(rd_n), .wr_n(wr_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .ram_we(ram_we),
        .ram_re(ram_re), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .y_err(y_err)
    );

    // behavioural reference state
    logic [7:0] m_x = 0;
    logic [6:0] m_y = 0;
    logic [3:0] m_ptr = 0;
    logic [2:0] m_bank = 0;
    bit         m_err = 0;
    bit         m_lrs = 0;
    bit         pend = 0;
    logic [7:0] pend_d = 0;
    logic       h_cs[4], h_rs[4], h_rd[4], h_wr[4];
    logic [7:0] h_d[4];

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [3:0] m_read(input logic [3:0] a);
        if (a == 4'hF) return m_ptr;
        if (a == 4'hE) return {1'b0, m_bank};
        if (m_bank != 0) return 4'hF;
        case (a)
            4'h0: return m_x[3:0];
            4'h1: return m_x[7:4];
            4'h2: return m_y[3:0];
            4'h3: return {1'b0, m_y[6:4]};
            default: return 4'hF;
        endcase
    endfunction

    task automatic m_write(input logic [7:0] b);
        logic [3:0] a = b[7:4];
        logic [3:0] d = b[3:0];
        logic [6:0] c;
        if (a == 4'hF) m_ptr = d;
        else if (a == 4'hE) m_bank = d[2:0];
        else if (m_bank == 0) begin
            case (a)
                4'h0: m_x[3:0] = d;
                4'h1: m_x[7:4] = d;
                4'h2: begin c = {m_y[6:4], d};      if (c <= 67) m_y = c; else m_err = 1; end
                4'h3: begin c = {d[2:0], m_y[3:0]}; if (c <= 67) m_y = c; else m_err = 1; end
                default: ;
            endcase
        end
    endtask

    function automatic bit rd_act(input int i);
        return !h_cs[i] && !h_rd[i] && h_wr[i];
    endfunction

    // cycle-by-cycle comparison against the reference
    initial begin
        for (int i = 0; i < 4; i++) begin
            h_cs[i] = 1; h_rs[i] = 0; h_rd[i] = 1; h_wr[i] = 1; h_d[i] = 0;
        end
        forever begin
            @(posedge clk);
            for (int i = 3; i > 0; i--) begin
                h_cs[i] = h_cs[i-1]; h_rs[i] = h_rs[i-1]; h_rd[i] = h_rd[i-1];
                h_wr[i] = h_wr[i-1]; h_d[i] = h_d[i-1];
            end
            h_cs[0] = cs_n; h_rs[0] = rs; h_rd[0] = rd_n; h_wr[0] = wr_n; h_d[0] = bus_in;
            #5;
            if (rst_n) begin
                bit commit, exp_we, exp_re, exp_oe;
                if (pend) begin m_write(pend_d); pend = 0; end
                exp_oe = rd_act(2);
                if (rd_act(2) && !rd_act(3)) m_lrs = h_rs[2];
                exp_re = rd_act(2) && !rd_act(3) && !h_rs[2];
                commit = h_wr[2] && !h_wr[3] && !h_cs[3];
                exp_we = commit && !h_rs[3];
                if (commit && h_rs[3]) begin pend = 1; pend_d = h_d[3]; end
                check("R4 bus_oe", bus_oe, exp_oe);
                check("R10 ram_we", ram_we, exp_we);
                check("R11 ram_re", ram_re, exp_re);
                check("R7 y_err", y_err, m_err);
                if (exp_we) begin
                    check("R10 ram_addr", ram_addr, {m_y, m_x});
                    check("R10 ram_wdata", ram_wdata, h_d[3]);
                end
                if (exp_oe && bus_oe) begin
                    if (m_lrs) check("R3 reg read bus", bus_out, {4'hF, m_read(m_ptr)});
                    else       check("R11 ram read bus", bus_out, ram_rdata);
                end
            end
        end
    end

    task automatic do_write(input logic r, input logic [7:0] d);
        @(negedge clk); cs_n = 0; rs = r; wr_n = 0; bus_in = d;
        repeat (3) @(negedge clk);
        wr_n = 1;
        @(negedge clk); cs_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(input logic r, output logic [7:0] v);
        @(negedge clk); cs_n = 0; rs = r; rd_n = 0;
        repeat (3) @(posedge clk);
        #5 v = bus_out;
        @(negedge clk); rd_n = 1; cs_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
        do_write(1, {4'hF, a});
        do_read(1, v);
    endtask

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #5;
        // R1 reset state
        check("R1 bus_oe", bus_oe, 0);
        check("R1 strobes", {ram_we, ram_re}, 0);
        check("R1 y_err", y_err, 0);
        check("R1 ram_addr", ram_addr, 0);
        do_read(1, v);
        check("R1 ptr=0 reads X lo 0", v, 8'hF0);

        // R2 R5 X address nibbles
        do_write(1, 8'h05);
        do_write(1, 8'h1A);
        rd_reg(4'h0, v); check("R5 X lo", v, 8'hF5);
        rd_reg(4'h1, v); check("R5 X hi", v, 8'hFA);
        // R2 R6 Y address nibbles, bit 3 ignored on upper part
        do_write(1, 8'h23);
        do_write(1, 8'h3C);
        rd_reg(4'h2, v); check("R6 Y lo", v, 8'hF3);
        rd_reg(4'h3, v); check("R6 Y hi bit3 ignored", v, 8'hF4);
        // R7 out-of-range Y discarded, flag sticky
        do_write(1, 8'h25);
        rd_reg(4'h2, v); check("R7 Y lo unchanged", v, 8'hF3);
        check("R7 y_err set", y_err, 1);
        // R10 RAM write carries {Y,X} and whole byte
        do_write(0, 8'h3C);
        rd_reg(4'h0, v); check("R10 regs untouched", v, 8'hF5);
        // R11 RAM read
        ram_rdata = 8'h96;
        do_read(0, v); check("R11 ram read data", v, 8'h96);
        ram_rdata = 8'h00;
        // R8 R12 bank select, bit 3 ignored
        do_write(1, 8'hE9);
        rd_reg(4'hE, v); check("R12 bank read", v, 8'hF1);
        do_write(1, 8'h07);
        rd_reg(4'h0, v); check("R8 X hidden in bank 1", v, 8'hFF);
        do_write(1, 8'hE8);
        rd_reg(4'h0, v); check("R8 X kept back in bank 0", v, 8'hF5);
        // R9 undefined address
        do_write(1, 8'h56);
        rd_reg(4'h5, v); check("R9 undefined reads F", v, 8'hFF);
        // R12 pointer read-back
        rd_reg(4'hF, v); check("R12 pointer read", v, 8'hFF);
        check("R7 y_err still set", y_err, 1);
        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule